// File: doc/BRIEF.md
# Instruction Predication Unit

This unit sits beside the issue stage of a small 32-bit core and decides, for every instruction issued, two things: whether the instruction is allowed to take effect, and whether it may update the arithmetic flags. Each instruction is judged against a 4-bit condition specifier. The specifier's low three bits select a test on the current zero, carry, negative and overflow flags. Its top bit is a freeze bit that blocks flag updates while still letting the instruction execute.

A 32-bit instruction carries its own specifier in its low nibble. A 16-bit instruction has no room for one, so it takes its specifier from a small pending queue. A conditions-setting instruction (CND) loads that queue with three specifiers, one for each of the next three issued instructions. When the queue is empty, a 16-bit instruction runs unconditionally. The all-zero 16-bit word is a NOP. It never writes flags. When it sits in the second slot of a 16-bit pair, it is skipped altogether.

Decoding the instruction word, generating new flag values and register writeback happen elsewhere. This unit only produces the two enables.

Top module: `predicate_ctl`

## Requirements
- R1: After reset the pending queue is empty, so a 16-bit instruction issued with any flags gives execute-enable 1 and flag-write-enable 1.
- R2: Specifier bits 2..0 select the test: 0 always, 1 overflow set, 2 zero set, 3 zero clear, 4 negative set, 5 negative clear, 6 carry set, 7 carry clear. The flag input has zero at bit 0, carry at bit 1, negative at bit 2 and overflow at bit 3.
- R3: When specifier bit 3 (freeze) is set and the test passes, execute-enable is 1 and flag-write-enable is 0.
- R4: When the test fails, both execute-enable and flag-write-enable are 0.
- R5: A 32-bit instruction (kind 01) is judged by its own specifier. If conditions are pending, it still uses up one queue entry.
- R6: A CND (kind 10) loads the queue. Payload bits 11..8 go to the first following instruction, bits 7..4 to the second and bits 3..0 to the third. The CND itself gives execute-enable 1 and flag-write-enable 0.
- R7: Each issued 16-bit instruction (kind 00) takes the queue head and advances the queue. After three entries have been used, 16-bit instructions fall back to specifier 0000.
- R8: A 16-bit NOP never gives flag-write-enable. A NOP in the first slot of a pair uses up a queue entry, and its execute-enable follows the test.
- R9: A 16-bit NOP marked as the second slot of a pair gives both enables 0 and leaves the queue untouched.
- R10: A CND issued while entries are still pending discards them and installs its own three.
- R11: With no issue strobe both enables are 0 and the queue keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction is issued this cycle |
| kind_i | input | 2 | 00 16-bit, 01 32-bit, 10 CND (11 treated as 32-bit) |
| cond_i | input | 4 | Specifier carried by a 32-bit instruction |
| cnd_payload_i | input | 12 | Three specifiers carried by a CND |
| nop_i | input | 1 | The 16-bit word is the all-zero NOP |
| second_slot_i | input | 1 | The 16-bit word is the second half of its pair |
| flags_i | input | 4 | Current flags: Z bit 0, C bit 1, N bit 2, V bit 3 |
| exec_en_o | output | 1 | Instruction may take effect |
| flag_we_o | output | 1 | Instruction may update the flags |

## Verification
Two functions can meet in one cycle. Consuming a queued specifier and reloading the queue collide when a CND is issued while entries are still pending. A skipped second-slot NOP collides with a queue head that it must not take. Both cases are provoked with directed sequences in which a stale or wrongly advanced entry would make a later 16-bit instruction fail its test. A long random run then mixes the kinds, NOP slots and flags. Every cycle is compared against a behavioural queue model kept in the bench.

// File: rtl/predicate_pkg.sv
package predicate_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;

    localparam int FREEZE_BIT = COND_W - 1;

    typedef enum logic [1:0] {
        KIND_SHORT = 2'b00,
        KIND_LONG  = 2'b01,
        KIND_CND   = 2'b10
    } ikind_e;

    typedef enum logic [2:0] {
        TST_ALWAYS = 3'd0,
        TST_V_SET  = 3'd1,
        TST_Z_SET  = 3'd2,
        TST_Z_CLR  = 3'd3,
        TST_N_SET  = 3'd4,
        TST_N_CLR  = 3'd5,
        TST_C_SET  = 3'd6,
        TST_C_CLR  = 3'd7
    } test_e;

endpackage

// File: rtl/cond_test.sv
module cond_test
    import predicate_pkg::*;
(
    input  logic [2:0]        test_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              pass_o
);

    always_comb begin
        unique case (test_e'(test_i))
            TST_ALWAYS: pass_o = 1'b1;
            TST_V_SET:  pass_o = flags_i[FLAG_V];
            TST_Z_SET:  pass_o = flags_i[FLAG_Z];
            TST_Z_CLR:  pass_o = ~flags_i[FLAG_Z];
            TST_N_SET:  pass_o = flags_i[FLAG_N];
            TST_N_CLR:  pass_o = ~flags_i[FLAG_N];
            TST_C_SET:  pass_o = flags_i[FLAG_C];
            TST_C_CLR:  pass_o = ~flags_i[FLAG_C];
            default:    pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cond_queue.sv
module cond_queue #(
    parameter int DEPTH = 3,
    parameter int CW    = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PL_W  = DEPTH * CW
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [PL_W-1:0]  load_data_i,
    input  logic             pop_i,
    output logic [CW-1:0]    head_o,
    output logic             pending_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] slot;
        logic [CNT_W-1:0]         cnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic [DEPTH-1:0][CW-1:0] unpacked_load;

    // entry 0 is the first following instruction: taken from the payload's top nibble
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_split
            assign unpacked_load[i] = load_data_i[(DEPTH-1-i)*CW +: CW];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.slot = unpacked_load;
            st_d.cnt  = CNT_W'(DEPTH);
        end else if (pop_i && (st_q.cnt != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
            st_d.cnt           = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o    = st_q.slot[0];
    assign pending_o = (st_q.cnt != '0);
    assign count_o   = st_q.cnt;

endmodule

// File: rtl/predicate_ctl.sv
module predicate_ctl
    import predicate_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    issue_i,
    input  logic [1:0]              kind_i,
    input  logic [COND_W-1:0]       cond_i,
    input  logic [DEPTH*COND_W-1:0] cnd_payload_i,
    input  logic                    nop_i,
    input  logic                    second_slot_i,
    input  logic [FLAG_W-1:0]       flags_i,
    output logic                    exec_en_o,
    output logic                    flag_we_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              is_short, is_cnd, is_nop, skip;
    logic [COND_W-1:0] head, eff_cond;
    logic              pending, pass, pop, load;
    logic [CNT_W-1:0]  pend_cnt;

    assign is_cnd   = (kind_i == KIND_CND);
    assign is_short = (kind_i == KIND_SHORT);
    assign is_nop   = is_short & nop_i;
    assign skip     = is_nop & second_slot_i;

    // 16-bit words take the queue head, or run unconditionally when it is empty
    always_comb begin
        if (is_short) begin
            eff_cond = pending ? head : '0;
        end else begin
            eff_cond = cond_i;
        end
    end

    assign load = issue_i & is_cnd;
    assign pop  = issue_i & ~is_cnd & ~skip & pending;

    cond_queue #(
        .DEPTH (DEPTH),
        .CW    (COND_W)
    ) u_queue (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .load_data_i (cnd_payload_i),
        .pop_i       (pop),
        .head_o      (head),
        .pending_o   (pending),
        .count_o     (pend_cnt)
    );

    cond_test u_test (
        .test_i  (eff_cond[2:0]),
        .flags_i (flags_i),
        .pass_o  (pass)
    );

    always_comb begin
        exec_en_o = 1'b0;
        flag_we_o = 1'b0;
        if (issue_i) begin
            if (is_cnd) begin
                exec_en_o = 1'b1;
            end else if (!skip) begin
                exec_en_o = pass;
                flag_we_o = pass & ~eff_cond[FREEZE_BIT] & ~is_nop;
            end
        end
    end

endmodule

// File: rtl/predicate_ctl_chk.sv
module predicate_ctl_chk #(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             issue_i,
    input logic [1:0]       kind_i,
    input logic             nop_i,
    input logic             second_slot_i,
    input logic             exec_en_o,
    input logic             flag_we_o,
    input logic [CNT_W-1:0] pend_cnt
);

    // R4
    we_needs_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_o |-> exec_en_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |-> (!exec_en_o && !flag_we_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> $stable(pend_cnt));

    // R6
    cnd_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && kind_i == 2'b10) |-> (exec_en_o && !flag_we_o));

    // R10
    cnd_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && kind_i == 2'b10) |=> (pend_cnt == CNT_W'(DEPTH)));

    // R8
    nop_no_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && kind_i == 2'b00 && nop_i) |-> !flag_we_o);

    // R9
    skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && kind_i == 2'b00 && nop_i && second_slot_i) |-> !exec_en_o);

    // R9
    skip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && kind_i == 2'b00 && nop_i && second_slot_i) |=> $stable(pend_cnt));

endmodule

bind predicate_ctl predicate_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_i       (issue_i),
    .kind_i        (kind_i),
    .nop_i         (nop_i),
    .second_slot_i (second_slot_i),
    .exec_en_o     (exec_en_o),
    .flag_we_o     (flag_we_o),
    .pend_cnt      (pend_cnt)
);

// File: tb/test_predicate_ctl.sv
`timescale 1ns/1ps
module test_predicate_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [3:0]  cond = 4'h0;
    logic [11:0] payload = 12'h0;
    logic        nop = 1'b0;
    logic        second = 1'b0;
    logic [3:0]  flags = 4'h0;
    logic        exec_en, flag_we;

    int checks = 0;
    int fails = 0;
    int q[$];

    always #10 clk = ~clk;

    predicate_ctl i_predicate_ctl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .issue_i       (issue),
        .kind_i        (kind),
        .cond_i        (cond),
        .cnd_payload_i (payload),
        .nop_i         (nop),
        .second_slot_i (second),
        .flags_i       (flags),
        .exec_en_o     (exec_en),
        .flag_we_o     (flag_we)
    );

    // flags: Z bit0, C bit1, N bit2, V bit3
    function automatic bit tpass(int c, logic [3:0] f);
        case (c & 7)
            0: return 1'b1;
            1: return f[3];
            2: return f[0];
            3: return !f[0];
            4: return f[2];
            5: return !f[2];
            6: return f[1];
            default: return !f[1];
        endcase
    endfunction

    task automatic step(string req, logic iss, logic [1:0] k, logic [3:0] c,
                        logic [11:0] pl, logic n, logic s, logic [3:0] f);
        bit e_x, e_w, consume;
        int cc;
        @(negedge clk);
        issue = iss; kind = k; cond = c; payload = pl; nop = n; second = s; flags = f;
        #5;
        e_x = 0; e_w = 0; consume = 0;
        if (iss) begin
            if (k == 2'b10) begin
                e_x = 1;
            end else if (!(k == 2'b00 && n && s)) begin
                if (k == 2'b00) cc = (q.size() > 0) ? q[0] : 0;
                else cc = int'(c);
                consume = (q.size() > 0);
                e_x = tpass(cc, f);
                e_w = e_x && !cc[3] && !(k == 2'b00 && n);
            end
        end
        checks++;
        if (exec_en !== e_x || flag_we !== e_w) begin
            fails++;
            $display("FAIL %s: exec=%b we=%b expected exec=%b we=%b", req,
                     exec_en, flag_we, e_x, e_w);
        end
        if (iss && k == 2'b10) q = '{int'(pl[11:8]), int'(pl[7:4]), int'(pl[3:0])};
        else if (consume) void'(q.pop_front());
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R11 and R1: reset state
        step("R11", 0, 2'b00, 4'h0, 12'h0, 0, 0, 4'h0);
        step("R1",  1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h0);
        step("R1",  1, 2'b00, 4'h0, 12'h0, 0, 0, 4'hF);
        // R2 / R4 / R3: every specifier against every flag pattern on 32-bit words
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                step(c < 8 ? "R2" : "R3", 1, 2'b01, 4'(c), 12'h0, 0, 0, 4'(f));
        // R6 order and R7 fallback
        step("R6", 1, 2'b10, 4'h0, 12'h236, 0, 0, 4'h3);
        step("R6", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h3);
        step("R4", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h3);
        step("R6", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h3);
        step("R7", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h0);
        // R9: skipped NOP keeps the head
        step("R9", 1, 2'b10, 4'h0, 12'h300, 0, 0, 4'h1);
        step("R9", 1, 2'b00, 4'h0, 12'h0, 1, 1, 4'h1);
        step("R9", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        // R8: first-slot NOP consumes, never writes flags
        step("R8", 1, 2'b10, 4'h0, 12'h300, 0, 0, 4'h1);
        step("R8", 1, 2'b00, 4'h0, 12'h0, 1, 0, 4'h1);
        step("R8", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R8", 1, 2'b00, 4'h0, 12'h0, 1, 0, 4'h0);
        // R5: 32-bit words use own specifier but advance the queue
        step("R5", 1, 2'b10, 4'h0, 12'h333, 0, 0, 4'h1);
        step("R5", 1, 2'b01, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R5", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R5", 1, 2'b01, 4'h2, 12'h0, 0, 0, 4'h1);
        step("R5", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        // R10: reload while pending
        step("R10", 1, 2'b10, 4'h0, 12'h333, 0, 0, 4'h1);
        step("R10", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R10", 1, 2'b10, 4'h0, 12'h800, 0, 0, 4'h1);
        step("R10", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R10", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R10", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        // R11: idle cycles leave the queue alone
        step("R11", 1, 2'b10, 4'h0, 12'h333, 0, 0, 4'h1);
        step("R11", 0, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R11", 0, 2'b01, 4'h0, 12'h0, 0, 0, 4'h1);
        step("R11", 1, 2'b00, 4'h0, 12'h0, 0, 0, 4'h1);
        // mixed traffic covering R7 R8 R9 R10
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            step("R7 mixed", $urandom_range(0, 5) != 0,
                 r < 5 ? 2'b00 : (r < 8 ? 2'b01 : 2'b10),
                 4'($urandom), 12'($urandom), $urandom_range(0, 3) == 0,
                 1'($urandom), 4'($urandom));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule